// File: doc/BRIEF.md
# Serial Audio Clock Activity Watchdog

This block supervises one serial audio channel for stalled timing signals. It watches three inputs that arrive from outside the system clock domain: the bit clock, the frame (word-select) clock and a DMA request line. Each input passes through its own synchronizer. A per-signal counter runs in system clocks and returns to zero whenever the synchronized signal changes level. If the counter reaches its programmed limit, a sticky status flag for that signal is raised. Software clears a flag by writing 1 to its bit.

The bit clock and the frame clock share one configuration word, made of an enable and a 20-bit limit. Each of the two still has its own flag. The DMA request line has a separate configuration word with an enable and a 16-bit limit. A single interrupt line is asserted while any flag is set. A status read returns the flags, and the register write path delivers a one-cycle clear strobe. Register decoding stays outside the block.

Top module: `audio_clk_watchdog`

## Requirements
- R1: The clock configuration word places the enable in bit 0 and the shared 20-bit limit in bits 20:1. The same limit applies to both the bit-clock and the frame-clock supervisors.
- R2: The DMA configuration word places the enable in bit 16 and the 16-bit limit in bits 15:0.
- R3: Each input is sampled through two flip-flops, and a level change is then detected one register later. Either direction of change returns that signal's counter to 0.
- R4: Flag positions are fixed: bit 0 is the bit clock, bit 1 is the frame clock and bit 2 is the DMA request. A signal that is enabled, has a nonzero limit N and shows no detected change has its flag set on the N-th rising clock edge of the stall.
- R5: A flag is raised once per stall. The counter then holds at the limit until the next detected change, so a flag cleared during a stall stays clear until the signal moves and a new full stall occurs.
- R6: While a supervisor is disabled, or its limit is 0, its counter is held at 0 and its flag is never set. Enabling it again restarts the count from 0.
- R7: A 1 in bit k of the clear strobe clears flag k at the next clock edge. A 0 leaves that flag unchanged.
- R8: If a clear and a new timeout for the same flag happen in the same cycle, the flag stays set.
- R9: The interrupt output is high exactly when at least one flag is set.
- R10: Synchronous reset drives all flags, the interrupt, the counters and the synchronizer stages to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Bit clock to supervise (asynchronous) |
| lrck_in | input | 1 | Frame clock to supervise (asynchronous) |
| dreq_in | input | 1 | DMA request line to supervise (asynchronous) |
| clk_chk_cfg | input | 21 | Enable in bit 0, shared clock limit in bits 20:1 |
| dma_chk_cfg | input | 17 | Enable in bit 16, DMA limit in bits 15:0 |
| flag_clr | input | 3 | One-cycle clear strobe, one bit per flag |
| flags | output | 3 | Sticky status flags: SCK, LRCK, DMA |
| irq | output | 1 | OR of all flags |

## Verification
The bench checks the exact cycle on which a flag rises for a given limit. A design that is one cycle off, or that leaves out a synchronizer stage, shows its flag one edge early or late. It also drives a clear in the same cycle as a timeout, where a design that lets the clear win drops the flag. Clearing a flag in the middle of a stall shows whether the counter really holds at the limit: a design that keeps counting or wraps around raises the flag a second time. Zero limits, disabled supervisors and clear bits written as 0 must each leave the flags untouched, and the random phase mixes edges, configuration changes and clears to catch any drift against the bench model.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int CLK_THR_W = 20;
    localparam int DMA_THR_W = 16;
    localparam int NUM_MON   = 3;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        MON_SCK  = 2'd0,
        MON_LRCK = 2'd1,
        MON_DREQ = 2'd2
    } mon_e;

    typedef struct packed {
        logic                 en;
        logic [CLK_THR_W-1:0] limit;
    } chk_cfg_t;

    function automatic chk_cfg_t unpack_clk_cfg(input logic [CLK_THR_W:0] word);
        chk_cfg_t c;
        c.en    = word[0];
        c.limit = word[CLK_THR_W:1];
        return c;
    endfunction

    function automatic chk_cfg_t unpack_dma_cfg(input logic [DMA_THR_W:0] word);
        chk_cfg_t c;
        c.en    = word[DMA_THR_W];
        c.limit = {{(CLK_THR_W-DMA_THR_W){1'b0}}, word[DMA_THR_W-1:0]};
        return c;
    endfunction

    function automatic logic cfg_active(input chk_cfg_t c);
        return c.en && (c.limit != '0);
    endfunction

endpackage

// File: rtl/awd_sync.sv
module awd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] change_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign level_o  = stage_q[STAGES-1];
    assign change_o = stage_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/awd_stall_timer.sv
module awd_stall_timer
    import awd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chk_cfg_t cfg_i,
    input  logic     change_i,
    output logic     timeout_o
);
    logic [CLK_THR_W-1:0] cnt_q;
    logic                 armed;
    logic                 at_edge_of_limit;

    assign armed            = cfg_active(cfg_i);
    assign at_edge_of_limit = (cnt_q == cfg_i.limit - CLK_THR_W'(1));
    assign timeout_o        = armed && !change_i && at_edge_of_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!armed || change_i) begin
            cnt_q <= '0;
        end else if (cnt_q < cfg_i.limit) begin
            cnt_q <= cnt_q + CLK_THR_W'(1);
        end
    end

endmodule

// File: rtl/awd_flag_bank.sv
module awd_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flag_q;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)           flag_q[k] <= 1'b0;
                else if (set_i[k]) flag_q[k] <= 1'b1;
                else if (clr_i[k]) flag_q[k] <= 1'b0;
            end
        end
    endgenerate

    assign flags_o = flag_q;

endmodule

// File: rtl/audio_clk_watchdog.sv
module audio_clk_watchdog
    import awd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_in,
    input  logic                 lrck_in,
    input  logic                 dreq_in,
    input  logic [CLK_THR_W:0]   clk_chk_cfg,
    input  logic [DMA_THR_W:0]   dma_chk_cfg,
    input  logic [NUM_MON-1:0]   flag_clr,
    output logic [NUM_MON-1:0]   flags,
    output logic                 irq
);
    logic [NUM_MON-1:0] raw_in;
    logic [NUM_MON-1:0] sync_lvl;
    logic [NUM_MON-1:0] sync_chg;
    logic [NUM_MON-1:0] tmo_hit;
    chk_cfg_t           cfg_sel [NUM_MON];

    assign raw_in[MON_SCK]  = sck_in;
    assign raw_in[MON_LRCK] = lrck_in;
    assign raw_in[MON_DREQ] = dreq_in;

    assign cfg_sel[MON_SCK]  = unpack_clk_cfg(clk_chk_cfg);
    assign cfg_sel[MON_LRCK] = unpack_clk_cfg(clk_chk_cfg);
    assign cfg_sel[MON_DREQ] = unpack_dma_cfg(dma_chk_cfg);

    awd_sync #(
        .WIDTH  (NUM_MON),
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_i  (raw_in),
        .level_o  (sync_lvl),
        .change_o (sync_chg)
    );

    genvar m;
    generate
        for (m = 0; m < NUM_MON; m++) begin : g_mon
            awd_stall_timer u_timer (
                .clk       (clk),
                .rst       (rst),
                .cfg_i     (cfg_sel[m]),
                .change_i  (sync_chg[m]),
                .timeout_o (tmo_hit[m])
            );
        end
    endgenerate

    awd_flag_bank #(
        .N (NUM_MON)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (tmo_hit),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    assign irq = |flags;

    logic unused_lvl;
    assign unused_lvl = ^sync_lvl;

endmodule

// File: rtl/awd_checker.sv
module awd_checker
    import awd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [CLK_THR_W:0]   clk_chk_cfg,
    input logic [DMA_THR_W:0]   dma_chk_cfg,
    input logic [NUM_MON-1:0]   flag_clr,
    input logic [NUM_MON-1:0]   flags,
    input logic                 irq,
    input logic [NUM_MON-1:0]   tmo
);
    AST_RESET_EMPTY: assert property (@(posedge clk) $past(rst) |-> (flags == '0 && !irq)); // R10

    AST_SCK_STICKY:  assert property (@(posedge clk) disable iff (rst) $fell(flags[0]) |-> $past(flag_clr[0])); // R7
    AST_LRCK_STICKY: assert property (@(posedge clk) disable iff (rst) $fell(flags[1]) |-> $past(flag_clr[1])); // R7
    AST_DREQ_STICKY: assert property (@(posedge clk) disable iff (rst) $fell(flags[2]) |-> $past(flag_clr[2])); // R7

    AST_SCK_ARMED:  assert property (@(posedge clk) disable iff (rst) $rose(flags[0]) |-> $past(clk_chk_cfg[0] && clk_chk_cfg[CLK_THR_W:1] != '0)); // R6
    AST_LRCK_ARMED: assert property (@(posedge clk) disable iff (rst) $rose(flags[1]) |-> $past(clk_chk_cfg[0] && clk_chk_cfg[CLK_THR_W:1] != '0)); // R6
    AST_DREQ_ARMED: assert property (@(posedge clk) disable iff (rst) $rose(flags[2]) |-> $past(dma_chk_cfg[DMA_THR_W] && dma_chk_cfg[DMA_THR_W-1:0] != '0)); // R6

    AST_SCK_TMO_WINS:  assert property (@(posedge clk) disable iff (rst) tmo[0] |=> flags[0]); // R8
    AST_LRCK_TMO_WINS: assert property (@(posedge clk) disable iff (rst) tmo[1] |=> flags[1]); // R8
    AST_DREQ_TMO_WINS: assert property (@(posedge clk) disable iff (rst) tmo[2] |=> flags[2]); // R8

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst) $fell(irq) |-> $past(flag_clr != '0)); // R9
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $past(tmo != '0)); // R9

endmodule

bind audio_clk_watchdog awd_checker u_awd_checker (
    .clk         (clk),
    .rst         (rst),
    .clk_chk_cfg (clk_chk_cfg),
    .dma_chk_cfg (dma_chk_cfg),
    .flag_clr    (flag_clr),
    .flags       (flags),
    .irq         (irq),
    .tmo         (tmo_hit)
);

// File: tb/audio_clk_watchdog_tb.sv
module audio_clk_watchdog_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_in = 1'b0, lrck_in = 1'b0, dreq_in = 1'b0;
    logic [20:0] clk_chk_cfg = '0;
    logic [16:0] dma_chk_cfg = '0;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  flags;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    audio_clk_watchdog u_dut (
        .clk         (clk),
        .rst         (rst),
        .sck_in      (sck_in),
        .lrck_in     (lrck_in),
        .dreq_in     (dreq_in),
        .clk_chk_cfg (clk_chk_cfg),
        .dma_chk_cfg (dma_chk_cfg),
        .flag_clr    (flag_clr),
        .flags       (flags),
        .irq         (irq)
    );

    // Bench model built from the requirements
    logic [2:0]  m_s1 = '0, m_s2 = '0, m_s3 = '0;
    int unsigned m_cnt [3];
    logic [2:0]  m_flag = '0;

    function automatic int unsigned lim_of(int i);
        if (i < 2) return int'(clk_chk_cfg[20:1]);   // R1
        return int'(dma_chk_cfg[15:0]);              // R2
    endfunction

    function automatic logic en_of(int i);
        if (i < 2) return clk_chk_cfg[0];
        return dma_chk_cfg[16];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_flag <= '0;
            for (int i = 0; i < 3; i++) m_cnt[i] <= 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                logic        chg, act, hit;
                int unsigned t;
                chg = m_s2[i] ^ m_s3[i];
                t   = lim_of(i);
                act = en_of(i) && (t != 0);
                hit = act && !chg && (m_cnt[i] == t - 1);
                m_flag[i] <= hit | (m_flag[i] & ~flag_clr[i]);
                if (!act || chg)   m_cnt[i] <= 0;
                else if (m_cnt[i] < t) m_cnt[i] <= m_cnt[i] + 1;
            end
            m_s1 <= {dreq_in, lrck_in, sck_in};
            m_s2 <= m_s1;
            m_s3 <= m_s2;
        end
    end

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {irq,flags} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        step(1);
        chk("R10 reset state", {irq, flags}, 4'b0000);

        // R4: exact boundary with limit 5, clock supervisors only
        clk_chk_cfg = {20'd5, 1'b1};
        step(4);
        chk("R4 before limit", {irq, flags}, 4'b0000);
        step(1);
        chk("R4 at limit, R1 shared", {irq, flags}, 4'b1011);

        // R8: clear collides with new timeout
        clk_chk_cfg = '0;
        step(1);
        clk_chk_cfg = {20'd3, 1'b1};
        step(2);
        flag_clr = 3'b011;
        step(1);
        flag_clr = '0;
        chk("R8 timeout beats clear", {irq, flags}, 4'b1011);

        // R7: zero clear bits do nothing, single bit clears only its flag
        step(3);
        chk("R7 clear of 0 ignored", {irq, flags}, 4'b1011);
        flag_clr = 3'b001;
        step(1);
        flag_clr = '0;
        chk("R7 clear bit 0 only", {irq, flags}, 4'b1010);

        // R5: no second raise during the same stall
        step(10);
        chk("R5 held counter", {irq, flags}, 4'b1010);
        // R3: toggle bit clock; change seen after sync, then 3-cycle stall
        sck_in = 1'b1;
        step(5);
        chk("R3 change restarts count", {irq, flags}, 4'b1010);
        step(1);
        chk("R3 new stall raises flag", {irq, flags}, 4'b1011);

        // R6: zero limit and disabled supervisor never raise
        flag_clr = 3'b111;
        clk_chk_cfg = {20'd0, 1'b1};
        step(1);
        flag_clr = '0;
        step(40);
        chk("R6 zero limit", {irq, flags}, 4'b0000);
        clk_chk_cfg = {20'd4, 1'b0};
        step(20);
        chk("R6 disabled", {irq, flags}, 4'b0000);

        // R2/R9: DMA supervisor alone, limit 7
        clk_chk_cfg = '0;
        dma_chk_cfg = {1'b1, 16'd7};
        step(6);
        chk("R2 dma before limit", {irq, flags}, 4'b0000);
        step(1);
        chk("R2 dma at limit, R9 irq", {irq, flags}, 4'b1100);
        flag_clr = 3'b100;
        step(1);
        flag_clr = '0;
        chk("R9 irq drops after clear", {irq, flags}, 4'b0000);
        dma_chk_cfg = '0;
        step(1);

        // Random phase against the bench model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 199) == 0) begin
                clk_chk_cfg = {20'($urandom_range(0, 24)), 1'($urandom_range(0, 5) != 0)};
                dma_chk_cfg = {1'($urandom_range(0, 5) != 0), 16'($urandom_range(0, 24))};
            end
            if ($urandom_range(0, 15) == 0) sck_in  = ~sck_in;
            if ($urandom_range(0, 31) == 0) lrck_in = ~lrck_in;
            if ($urandom_range(0, 23) == 0) dreq_in = ~dreq_in;
            flag_clr = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
            if (n == 0) begin
                clk_chk_cfg = {20'd9, 1'b1};
                dma_chk_cfg = {1'b1, 16'd12};
            end
            step(1);
            chk("R3 R4 R5 R7 R8 R9 random vs model", {irq, flags}, {|m_flag, m_flag});
        end

        flag_clr = '0;
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        chk("R10 reset after traffic", {irq, flags}, 4'b0000);
        finish_run();
    end

endmodule